// File: doc/BRIEF.md
# Peripheral Timer and Interrupt Register File

This block is the byte-wide register file of a parallel-interface-adapter style peripheral. It contains two 16-bit down-counting timers, each with its own latch, plus storage for a shift byte, an auxiliary-control byte and a peripheral-control byte. It also holds a seven-bit interrupt flag register and a seven-bit interrupt enable register, and it drives one combined active-high interrupt request.

A CPU reaches the block over a simple synchronous bus: chip select, address, read strobe, write strobe and write data. Each access completes in the clock cycle in which its strobe is sampled. Only the four low address bits pick a register, so the sixteen locations repeat throughout the block's address window. Several accesses have side effects. Some reads and writes clear interrupt flags, and a write to a timer's upper latch byte starts that timer. The enable register is changed by set/clear writes. The top bit of a flag read is computed when the read happens. Read data is registered and appears one cycle after the read strobe.

Timer 1 runs freely and reloads from its latch every time it passes zero. Timer 2 counts once through zero after each start and then keeps wrapping without raising its flag again. Port pins, shift clocking and handshake modes are not part of this block.

Top module: `ptimer_irq_regs`

## Requirements
- R1: Only address bits [3:0] select a register, so every location repeats throughout the address window. Offsets 10, 11 and 12 are plain read/write bytes (shift, auxiliary control, peripheral control). Offsets 0-3 and 15 read as 8'h00 and ignore writes.
- R2: After reset the flag, enable, shift, auxiliary-control and peripheral-control registers are zero, and both timer counters and the timer-1 latch are 16'hFFFF.
- R3: A write to offset 4 or offset 6 changes only the low byte of the timer-1 latch. A read of offset 6 or offset 7 returns the latch's low or high byte.
- R4: A write to offset 5 stores the latch high byte, loads the whole latch into the timer-1 counter in the same cycle, and clears flag bit 6.
- R5: A write to offset 7 stores the latch high byte without loading the counter and without changing any flag.
- R6: A read of offset 4 returns the low byte of the timer-1 counter and clears flag bit 6. A read of offset 5 returns the counter high byte and has no side effect.
- R7: A write to offset 8 sets the timer-2 latch low byte. A write to offset 9 sets the latch high byte, loads the timer-2 counter and clears flag bit 5. A read of offset 8 returns the counter low byte and clears flag bit 5. A read of offset 9 returns the counter high byte.
- R8: The timer-1 counter decrements once per clock. In the cycle after it holds zero it reloads from its latch and sets flag bit 6, so a latch value L gives a period of L+1 cycles.
- R9: The timer-2 counter decrements once per clock and wraps from zero to 16'hFFFF. It sets flag bit 5 only on the first pass through zero after a load at offset 9.
- R10: A write to offset 13 clears each flag bit whose written bit is 1 and leaves the others unchanged.
- R11: A read of offset 13 returns the flag bits in [6:0], with bit 7 equal to 1 exactly when some flag bit and its enable bit are both 1.
- R12: A write to offset 14 with bit 7 = 1 sets the enable bits marked by ones in [6:0]. With bit 7 = 0 it clears them. A read of offset 14 returns the enables with bit 7 forced to 1.
- R13: The output irq is 1 exactly while (flags & enables) is non-zero, and it follows a flag or enable change from the next cycle on.
- R14: When a flag is set and cleared in the same cycle, the set wins. When a timer load write and an underflow of that timer fall in the same cycle, the load wins: the counter takes the latch value and no flag is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cs | input | 1 | Chip select for the bus access |
| addr | input | ADDR_W (10) | Byte address within the window; bits [3:0] select the register |
| rd | input | 1 | Read strobe |
| wr | input | 1 | Write strobe |
| wdata | input | DATA_W (8) | Write data |
| rd_data | output | DATA_W (8) | Registered read data, valid the cycle after the read strobe |
| irq | output | 1 | Combined active-high interrupt request |

## Verification
Two functions can collide in one clock: a timer underflow that sets a flag, and a bus access that clears the same flag. The clearing access may be a write to the flag register or a reload write to the timer. The bench loads timer 1 with a short latch, counts the cycles of its L+1 period, and places the clearing access exactly on the underflow edge. A flag read in the next cycle shows whether the set won. A reload write placed on the underflow edge is judged the same way: the flag must stay clear and the counter must restart from the latch.

// File: rtl/ptir_pkg.sv
package ptir_pkg;

   // Register offsets whose behaviour the block decodes
   typedef enum logic [3:0] {
      SEL_T1_CNT_LO = 4'd4,
      SEL_T1_CNT_HI = 4'd5,
      SEL_T1_LAT_LO = 4'd6,
      SEL_T1_LAT_HI = 4'd7,
      SEL_T2_LO     = 4'd8,
      SEL_T2_HI     = 4'd9,
      SEL_SHIFT     = 4'd10,
      SEL_AUX       = 4'd11,
      SEL_PER       = 4'd12,
      SEL_FLAGS     = 4'd13,
      SEL_ENABLE    = 4'd14
   } reg_sel_e;

   localparam int FLAG_T1 = 6;   // timer-1 underflow flag bit
   localparam int FLAG_T2 = 5;   // timer-2 underflow flag bit
   localparam int NUM_SEL = 16;  // locations decoded by addr[3:0]

endpackage

// File: rtl/ptir_timer.sv
module ptir_timer #(
   parameter int TMR_W    = 16,
   parameter int DATA_W   = 8,
   parameter bit ONE_SHOT = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              lat_lo_we,
   input  logic              lat_hi_we,
   input  logic              load_we,
   input  logic [DATA_W-1:0] wdata,
   output logic [TMR_W-1:0]  cnt_q,
   output logic [TMR_W-1:0]  lat_q,
   output logic              underflow
);

   localparam int HI_W = TMR_W - DATA_W;

   logic             armed;
   logic [TMR_W-1:0] wrap_val;
   logic             at_zero;

   assign at_zero = (cnt_q == '0);

   generate
      if (ONE_SHOT) begin : g_oneshot
         logic armed_q;
         always_ff @(posedge clk) begin
            if (!rst_n)
               armed_q <= 1'b0;
            else if (load_we)
               armed_q <= 1'b1;
            else if (at_zero)
               armed_q <= 1'b0;
         end
         assign armed    = armed_q;
         assign wrap_val = '1;
      end else begin : g_reload
         assign armed    = 1'b1;
         assign wrap_val = lat_q;
      end
   endgenerate

   // A load in the same cycle suppresses the underflow event
   assign underflow = at_zero && armed && !load_we;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         lat_q <= '1;
         cnt_q <= '1;
      end else begin
         if (lat_lo_we)
            lat_q[DATA_W-1:0] <= wdata;
         if (lat_hi_we)
            lat_q[TMR_W-1:DATA_W] <= wdata[HI_W-1:0];
         if (load_we)
            cnt_q <= {wdata[HI_W-1:0], lat_q[DATA_W-1:0]};
         else if (at_zero)
            cnt_q <= wrap_val;
         else
            cnt_q <= cnt_q - 1'b1;
      end
   end

endmodule

// File: rtl/ptir_irq.sv
module ptir_irq #(
   parameter int FLAG_W = 7
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [FLAG_W-1:0] set_vec,
   input  logic [FLAG_W-1:0] clr_vec,
   input  logic              ena_we,
   input  logic              ena_mode_set,
   input  logic [FLAG_W-1:0] ena_bits,
   output logic [FLAG_W-1:0] flag_q,
   output logic [FLAG_W-1:0] ena_q,
   output logic              irq
);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         flag_q <= '0;
         ena_q  <= '0;
      end else begin
         // set dominates clear so that no event is lost
         flag_q <= (flag_q & ~clr_vec) | set_vec;
         if (ena_we) begin
            if (ena_mode_set)
               ena_q <= ena_q | ena_bits;
            else
               ena_q <= ena_q & ~ena_bits;
         end
      end
   end

   assign irq = |(flag_q & ena_q);

endmodule

// File: rtl/ptir_rdmux.sv
module ptir_rdmux
   import ptir_pkg::*;
#(
   parameter int TMR_W  = 16,
   parameter int DATA_W = 8,
   parameter int FLAG_W = 7
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              rd_en,
   input  logic [3:0]        sel,
   input  logic [TMR_W-1:0]  t1_cnt,
   input  logic [TMR_W-1:0]  t1_lat,
   input  logic [TMR_W-1:0]  t2_cnt,
   input  logic [DATA_W-1:0] shift_q,
   input  logic [DATA_W-1:0] aux_q,
   input  logic [DATA_W-1:0] per_q,
   input  logic [FLAG_W-1:0] flag_q,
   input  logic [FLAG_W-1:0] ena_q,
   input  logic              irq,
   output logic [DATA_W-1:0] rd_data
);

   localparam int HI_W = TMR_W - DATA_W;

   logic [DATA_W-1:0] mux_d;

   always_comb begin
      mux_d = '0;
      case (reg_sel_e'(sel))
         SEL_T1_CNT_LO: mux_d = t1_cnt[DATA_W-1:0];
         SEL_T1_CNT_HI: mux_d = DATA_W'(t1_cnt[TMR_W-1:DATA_W]);
         SEL_T1_LAT_LO: mux_d = t1_lat[DATA_W-1:0];
         SEL_T1_LAT_HI: mux_d = DATA_W'(t1_lat[TMR_W-1:DATA_W]);
         SEL_T2_LO:     mux_d = t2_cnt[DATA_W-1:0];
         SEL_T2_HI:     mux_d = DATA_W'(t2_cnt[TMR_W-1:DATA_W]);
         SEL_SHIFT:     mux_d = shift_q;
         SEL_AUX:       mux_d = aux_q;
         SEL_PER:       mux_d = per_q;
         SEL_FLAGS:     mux_d = {irq, flag_q};
         SEL_ENABLE:    mux_d = {1'b1, ena_q};
         default:       mux_d = '0;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n)
         rd_data <= '0;
      else if (rd_en)
         rd_data <= mux_d;
   end

endmodule

// File: rtl/ptimer_irq_regs.sv
module ptimer_irq_regs
   import ptir_pkg::*;
#(
   parameter int ADDR_W = 10,
   parameter int DATA_W = 8,
   parameter int TMR_W  = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cs,
   input  logic [ADDR_W-1:0] addr,
   input  logic              rd,
   input  logic              wr,
   input  logic [DATA_W-1:0] wdata,
   output logic [DATA_W-1:0] rd_data,
   output logic              irq
);

   localparam int FLAG_W = DATA_W - 1;

   generate
      if (ADDR_W < 4 || DATA_W < 8 || TMR_W != 2 * DATA_W) begin : g_bad_cfg
         $error("ptimer_irq_regs: unsupported ADDR_W/DATA_W/TMR_W combination");
      end
      if (ADDR_W > 4) begin : g_window
         logic unused_hi;
         assign unused_hi = ^addr[ADDR_W-1:4];
      end
   endgenerate

   // ---------------- access decode ----------------
   logic                wr_hit, rd_hit;
   logic [3:0]          reg_sel;
   logic [NUM_SEL-1:0]  wr_dec, rd_dec;

   assign wr_hit  = cs & wr;
   assign rd_hit  = cs & rd;
   assign reg_sel = addr[3:0];

   generate
      for (genvar i = 0; i < NUM_SEL; i++) begin : g_dec
         assign wr_dec[i] = wr_hit && (reg_sel == 4'(i));
         assign rd_dec[i] = rd_hit && (reg_sel == 4'(i));
      end
   endgenerate

   // ---------------- timers ----------------
   logic [TMR_W-1:0] t1_cnt, t1_lat, t2_cnt, t2_lat_unused;
   logic             t1_uf, t2_uf;

   ptir_timer #(.TMR_W(TMR_W), .DATA_W(DATA_W), .ONE_SHOT(1'b0)) u_t1 (
      .clk       (clk),
      .rst_n     (rst_n),
      .lat_lo_we (wr_dec[SEL_T1_CNT_LO] | wr_dec[SEL_T1_LAT_LO]),
      .lat_hi_we (wr_dec[SEL_T1_CNT_HI] | wr_dec[SEL_T1_LAT_HI]),
      .load_we   (wr_dec[SEL_T1_CNT_HI]),
      .wdata     (wdata),
      .cnt_q     (t1_cnt),
      .lat_q     (t1_lat),
      .underflow (t1_uf)
   );

   ptir_timer #(.TMR_W(TMR_W), .DATA_W(DATA_W), .ONE_SHOT(1'b1)) u_t2 (
      .clk       (clk),
      .rst_n     (rst_n),
      .lat_lo_we (wr_dec[SEL_T2_LO]),
      .lat_hi_we (wr_dec[SEL_T2_HI]),
      .load_we   (wr_dec[SEL_T2_HI]),
      .wdata     (wdata),
      .cnt_q     (t2_cnt),
      .lat_q     (t2_lat_unused),
      .underflow (t2_uf)
   );

   // ---------------- plain control bytes ----------------
   logic [DATA_W-1:0] shift_q, aux_q, per_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         shift_q <= '0;
         aux_q   <= '0;
         per_q   <= '0;
      end else begin
         if (wr_dec[SEL_SHIFT]) shift_q <= wdata;
         if (wr_dec[SEL_AUX])   aux_q   <= wdata;
         if (wr_dec[SEL_PER])   per_q   <= wdata;
      end
   end

   // ---------------- flag set / clear sources ----------------
   logic [FLAG_W-1:0] set_vec, clr_vec, flag_q, ena_q;

   always_comb begin
      set_vec          = '0;
      set_vec[FLAG_T1] = t1_uf;
      set_vec[FLAG_T2] = t2_uf;

      clr_vec = '0;
      if (wr_dec[SEL_FLAGS])
         clr_vec = wdata[FLAG_W-1:0];
      if (rd_dec[SEL_T1_CNT_LO] || wr_dec[SEL_T1_CNT_HI])
         clr_vec[FLAG_T1] = 1'b1;
      if (rd_dec[SEL_T2_LO] || wr_dec[SEL_T2_HI])
         clr_vec[FLAG_T2] = 1'b1;
   end

   ptir_irq #(.FLAG_W(FLAG_W)) u_irq (
      .clk          (clk),
      .rst_n        (rst_n),
      .set_vec      (set_vec),
      .clr_vec      (clr_vec),
      .ena_we       (wr_dec[SEL_ENABLE]),
      .ena_mode_set (wdata[DATA_W-1]),
      .ena_bits     (wdata[FLAG_W-1:0]),
      .flag_q       (flag_q),
      .ena_q        (ena_q),
      .irq          (irq)
   );

   // ---------------- read path ----------------
   ptir_rdmux #(.TMR_W(TMR_W), .DATA_W(DATA_W), .FLAG_W(FLAG_W)) u_rd (
      .clk     (clk),
      .rst_n   (rst_n),
      .rd_en   (rd_hit),
      .sel     (reg_sel),
      .t1_cnt  (t1_cnt),
      .t1_lat  (t1_lat),
      .t2_cnt  (t2_cnt),
      .shift_q (shift_q),
      .aux_q   (aux_q),
      .per_q   (per_q),
      .flag_q  (flag_q),
      .ena_q   (ena_q),
      .irq     (irq),
      .rd_data (rd_data)
   );

endmodule

// File: rtl/ptir_checker.sv
module ptir_checker
   import ptir_pkg::*;
#(
   parameter int DATA_W = 8,
   parameter int TMR_W  = 16,
   parameter int FLAG_W = 7
) (
   input logic              clk,
   input logic              rst_n,
   input logic              wr_hit,
   input logic              rd_hit,
   input logic [3:0]        sel,
   input logic [DATA_W-1:0] rd_data,
   input logic              irq,
   input logic [TMR_W-1:0]  t1_cnt,
   input logic [TMR_W-1:0]  t1_lat,
   input logic [TMR_W-1:0]  t2_cnt,
   input logic [FLAG_W-1:0] flag_q,
   input logic [FLAG_W-1:0] ena_q
);

   // R2: state is cleared when reset is released
   assert_reset_clear_R2: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_n) |-> (flag_q == '0 && ena_q == '0))
      else $error("R2 flags/enables not clear after reset");

   // R8: timer 1 counts down by one when idle and not at zero
   assert_t1_dec_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (t1_cnt != '0 && !wr_hit) |=> (t1_cnt == $past(t1_cnt) - 1'b1))
      else $error("R8 timer-1 decrement");

   // R8: timer 1 reloads from the latch after zero
   assert_t1_reload_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (t1_cnt == '0 && !wr_hit) |=> (t1_cnt == $past(t1_lat)))
      else $error("R8 timer-1 reload");

   // R8: timer 1 underflow raises its flag
   assert_t1_flag_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (t1_cnt == '0 && !wr_hit) |=> flag_q[FLAG_T1])
      else $error("R8 timer-1 flag");

   // R9: timer 2 wraps to all ones
   assert_t2_wrap_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (t2_cnt == '0 && !wr_hit) |=> (t2_cnt == '1))
      else $error("R9 timer-2 wrap");

   // R12: enable reads always show bit 7 set
   assert_ena_top_R12: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_hit && sel == 4'd14) |=> rd_data[DATA_W-1])
      else $error("R12 enable read top bit");

   // R13: flag read top bit matches the request line seen at the read
   assert_flag_top_R13: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_hit && sel == 4'd13) |=> (rd_data[DATA_W-1] == $past(irq)))
      else $error("R13 flag read top bit vs irq");

   // R14: an underflow beats a flag-register clear in the same cycle
   assert_set_wins_R14: assert property (@(posedge clk) disable iff (!rst_n)
      (t1_cnt == '0 && wr_hit && sel == 4'd13) |=> flag_q[FLAG_T1])
      else $error("R14 set must win over clear");

endmodule

bind ptimer_irq_regs ptir_checker #(
   .DATA_W (DATA_W),
   .TMR_W  (TMR_W),
   .FLAG_W (FLAG_W)
) u_ptir_checker (
   .clk     (clk),
   .rst_n   (rst_n),
   .wr_hit  (wr_hit),
   .rd_hit  (rd_hit),
   .sel     (reg_sel),
   .rd_data (rd_data),
   .irq     (irq),
   .t1_cnt  (t1_cnt),
   .t1_lat  (t1_lat),
   .t2_cnt  (t2_cnt),
   .flag_q  (flag_q),
   .ena_q   (ena_q)
);

// File: tb/ptimer_irq_regs_bench.sv
module ptimer_irq_regs_bench;

   localparam int HALF = 10;   // 50 MHz

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       cs = 1'b0, rd = 1'b0, wr = 1'b0;
   logic [9:0] addr = '0;
   logic [7:0] wdata = '0;
   logic [7:0] rd_data;
   logic       irq;

   ptimer_irq_regs u_ptimer_irq_regs (
      .clk(clk), .rst_n(rst_n), .cs(cs), .addr(addr), .rd(rd), .wr(wr),
      .wdata(wdata), .rd_data(rd_data), .irq(irq)
   );

   always #HALF clk = ~clk;

   int  n_cmp = 0;
   int  n_bad = 0;
   bit  done  = 1'b0;

   // scoreboard queues
   logic [7:0] q_exp[$];
   logic [7:0] q_mask[$];
   string      q_tag[$];

   logic fire = 1'b0;
   always @(posedge clk) fire <= cs & rd;

   // monitor: compare registered read data one cycle after the strobe
   always @(negedge clk) begin
      if (fire) begin
         n_cmp++;
         if (q_exp.size() == 0) begin
            n_bad++;
            $display("FAIL scoreboard: unexpected read data actual=%02h expected=none", rd_data);
         end else begin
            logic [7:0] e, m;
            string      t;
            e = q_exp.pop_front();
            m = q_mask.pop_front();
            t = q_tag.pop_front();
            if ((rd_data & m) !== (e & m)) begin
               n_bad++;
               $display("FAIL %s: actual=%02h expected=%02h (mask %02h)", t, rd_data, e, m);
            end
         end
      end
   end

   task automatic op(input logic c, input logic r, input logic w,
                     input logic [9:0] a, input logic [7:0] d);
      cs = c; rd = r; wr = w; addr = a; wdata = d;
      @(negedge clk);
   endtask

   task automatic bwr(input logic [9:0] a, input logic [7:0] d);
      op(1'b1, 1'b0, 1'b1, a, d);
   endtask

   task automatic brd(input logic [9:0] a, input logic [7:0] e,
                      input logic [7:0] m, input string t);
      q_exp.push_back(e);
      q_mask.push_back(m);
      q_tag.push_back(t);
      op(1'b1, 1'b1, 1'b0, a, 8'h00);
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) op(1'b0, 1'b0, 1'b0, 10'h000, 8'h00);
   endtask

   task automatic chk_irq(input logic e, input string t);
      n_cmp++;
      if (irq !== e) begin
         n_bad++;
         $display("FAIL %s: irq actual=%0b expected=%0b", t, irq, e);
      end
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   endtask

   initial begin
      #(2 * HALF * 300000);
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      finish_run();
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // ---- R2 reset state ----
      chk_irq(1'b0, "R2 irq after reset");
      brd(10'h00D, 8'h00, 8'hFF, "R2 flags reset");
      brd(10'h00E, 8'h80, 8'hFF, "R2 enables reset");
      brd(10'h00B, 8'h00, 8'hFF, "R2 aux reset");
      brd(10'h00C, 8'h00, 8'hFF, "R2 per reset");
      brd(10'h00A, 8'h00, 8'hFF, "R2 shift reset");
      brd(10'h006, 8'hFF, 8'hFF, "R2 t1 latch lo reset");
      brd(10'h007, 8'hFF, 8'hFF, "R2 t1 latch hi reset");

      // ---- R1 decode and mirroring ----
      bwr(10'h00B, 8'hA5);
      brd(10'h3FB, 8'hA5, 8'hFF, "R1 aux mirrored read");
      bwr(10'h15C, 8'h3C);
      brd(10'h00C, 8'h3C, 8'hFF, "R1 per mirrored write");
      bwr(10'h20A, 8'h5A);
      brd(10'h01A, 8'h5A, 8'hFF, "R1 shift mirrored");
      bwr(10'h000, 8'h77);
      brd(10'h000, 8'h00, 8'hFF, "R1 unused offset reads zero");

      // ---- R3 / R5 latch-only writes ----
      bwr(10'h004, 8'h34);
      brd(10'h006, 8'h34, 8'hFF, "R3 offset 4 writes latch lo");
      bwr(10'h006, 8'h56);
      brd(10'h006, 8'h56, 8'hFF, "R3 offset 6 writes latch lo");
      brd(10'h007, 8'hFF, 8'hFF, "R3 latch hi untouched");
      bwr(10'h007, 8'h12);
      brd(10'h007, 8'h12, 8'hFF, "R5 offset 7 writes latch hi");
      brd(10'h005, 8'hFF, 8'hFF, "R5 counter not loaded by offset 7");
      brd(10'h00D, 8'h00, 8'hFF, "R5 no flag change");

      // ---- timer 1: latch 5, period 6 (load at E0) ----
      bwr(10'h004, 8'h05);
      bwr(10'h005, 8'h00);                                   // E0
      brd(10'h004, 8'h05, 8'hFF, "R4 counter loaded from latch"); // E0+1
      brd(10'h004, 8'h04, 8'hFF, "R8 decrement");            // E0+2
      brd(10'h005, 8'h00, 8'hFF, "R6 counter hi");           // E0+3
      idle(2);                                               // E0+4,5
      brd(10'h00D, 8'h00, 8'hFF, "R8 flag not yet set");     // E0+6 underflow
      brd(10'h00D, 8'h40, 8'hFF, "R8 flag 6 set");           // E0+7
      brd(10'h004, 8'h04, 8'hFF, "R8 reloaded counter");     // E0+8 clears
      brd(10'h00D, 8'h00, 8'hFF, "R6 read lo clears flag 6");// E0+9
      idle(3);                                               // E0+10..12
      brd(10'h005, 8'h00, 8'hFF, "R6 read hi");              // E0+13
      brd(10'h00D, 8'h40, 8'hFF, "R6 read hi keeps flag");   // E0+14
      bwr(10'h005, 8'h00);                                   // E0+15
      brd(10'h00D, 8'h00, 8'hFF, "R4 write hi clears flag 6");// E0+16
      bwr(10'h00E, 8'hC0);                                   // E0+17
      brd(10'h00E, 8'hC0, 8'hFF, "R12 enable set");          // E0+18
      chk_irq(1'b0, "R13 enabled but no flag");
      idle(3);                                               // E0+19..21
      chk_irq(1'b1, "R13 flag and enable");
      brd(10'h00D, 8'hC0, 8'hFF, "R11 top bit set");         // E0+22
      bwr(10'h00E, 8'h40);                                   // E0+23
      chk_irq(1'b0, "R13 enable cleared");
      brd(10'h00E, 8'h80, 8'hFF, "R12 enable clear");        // E0+24
      brd(10'h00D, 8'h40, 8'hFF, "R11 top bit clear");       // E0+25
      idle(1);                                               // E0+26
      bwr(10'h00D, 8'h40);                                   // E0+27 collision
      brd(10'h00D, 8'h40, 8'hFF, "R14 set wins over clear"); // E0+28
      bwr(10'h00D, 8'h40);                                   // E0+29
      brd(10'h00D, 8'h00, 8'hFF, "R10 write-one clears");    // E0+30
      bwr(10'h004, 8'hFF);                                   // E0+31
      idle(1);                                               // E0+32
      bwr(10'h005, 8'hFF);                                   // E0+33 load on underflow
      brd(10'h00D, 8'h00, 8'hFF, "R14 load wins, no flag");  // E0+34
      brd(10'h005, 8'hFF, 8'hFF, "R14 load wins, counter");  // E0+35

      // ---- timer 2 (load at F+1) ----
      bwr(10'h008, 8'h03);                                   // F
      bwr(10'h009, 8'h00);                                   // F+1
      brd(10'h008, 8'h03, 8'hFF, "R7 t2 loaded lo");         // F+2
      brd(10'h009, 8'h00, 8'hFF, "R7 t2 hi");                // F+3
      idle(1);                                               // F+4
      brd(10'h00D, 8'h00, 8'hFF, "R9 flag not yet set");     // F+5 underflow
      brd(10'h00D, 8'h20, 8'hFF, "R9 flag 5 set");           // F+6
      brd(10'h009, 8'hFF, 8'hFF, "R9 wrapped to all ones");  // F+7
      brd(10'h008, 8'hFD, 8'hFF, "R9 keeps counting");       // F+8
      brd(10'h00D, 8'h00, 8'hFF, "R7 read lo clears flag 5");// F+9
      bwr(10'h008, 8'h02);
      bwr(10'h009, 8'h00);
      idle(3);
      brd(10'h00D, 8'h20, 8'hFF, "R9 flag on new load");
      bwr(10'h009, 8'h00);
      brd(10'h00D, 8'h00, 8'hFF, "R7 write hi clears flag 5");
      idle(2);
      bwr(10'h00E, 8'hA0);
      chk_irq(1'b1, "R13 timer-2 request");
      brd(10'h00D, 8'hA0, 8'hFF, "R11 top bit from flag 5");
      bwr(10'h00E, 8'h20);
      chk_irq(1'b0, "R12 enable 5 cleared");
      bwr(10'h00D, 8'h20);
      brd(10'h00D, 8'h00, 8'h20, "R10 flag 5 cleared");
      idle(65600);
      brd(10'h00D, 8'h00, 8'h20, "R9 one-shot, no second flag");

      idle(2);
      finish_run();
   end

endmodule